// File: doc/BRIEF.md
# Event Channel Generator Router

This block is one event channel. Any of several generator inputs can be routed to the channel's users, and one code register picks which one. Each generator has two fixed tags, set by parameter. The first says whether it makes single-cycle pulses or multi-cycle levels. The second says whether it runs on the peripheral clock or comes from another clock or from no clock at all. The tags decide how the chosen event reaches the synchronous channel output.

- A synchronous generator passes straight through.
- A foreign-domain pulse is captured with a toggle flop in its own clock domain. It is then synchronized and edge-detected into exactly one peripheral-clock pulse.
- An unclocked level goes through a two-flop synchronizer.

A second output carries the raw, unflopped signal of an asynchronous generator, so the event can still reach users while the peripheral clock is stopped.

Code 0 selects nothing, and so does any code above the number of generators. Every write to the code register holds the synchronous output low for one cycle and clears all synchronizer state, so that a change of source cannot produce a stray event.

Top module: `evt_chan_router`

## Requirements
- R1: Code k, for k from 1 to N_GEN, selects generator k-1, and only that generator affects the outputs. A code written with `sel_we` high takes effect at that rising edge of `clk`.
- R2: After reset the code is 0 (no generator), `evt_sync` and `evt_raw` are 0, and both tag outputs are 0.
- R3: When the selected generator is tagged synchronous, `evt_sync` equals that input in the same cycle, without a register. A one-cycle pulse stays one cycle wide, and a held level stays high for as many cycles as it is held.
- R4: When the selected generator is an asynchronous pulse source, each pulse seen on its own clock produces exactly one `evt_sync` pulse, one `clk` cycle wide. This holds when source pulses are at least three `clk` cycles apart.
- R5: When the selected generator is an asynchronous level, `evt_sync` follows it with a latency of two `clk` edges.
- R6: When the selected generator is tagged asynchronous, `evt_raw` equals its input with no clocked stage, including while `clk` is stopped.
- R7: `evt_raw` is 0 whenever the selection is a synchronous generator or no generator.
- R8: In the cycle after any write to the code register, `evt_sync` is 0. All synchronizer state is cleared at that write edge, so a newly selected asynchronous level reaches `evt_sync` only two edges after the write.
- R9: A code greater than N_GEN behaves exactly like code 0. Both outputs and both tags read 0, whatever the inputs do.
- R10: `sel_is_pulse` and `sel_is_async` show the pulse tag and the asynchronous tag of the selected generator, and are 0 when nothing is selected. With the default parameters the generators are indexed 0 to 5:
  - pulse tag bits, index 5 down to 0: 010101
  - asynchronous tag bits, index 5 down to 0: 111100

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_we | input | 1 | Write strobe for the selection code |
| sel_wdata | input | SEL_W | Selection code: 0 for none, k for generator k-1 |
| gen_evt | input | N_GEN | Event inputs from the generators |
| src_clk | input | N_GEN | Source clock of each asynchronous pulse generator (ignored for the others) |
| evt_sync | output | 1 | Channel event for synchronous users |
| evt_raw | output | 1 | Unclocked channel event from asynchronous generators |
| sel_is_pulse | output | 1 | Pulse tag of the selected generator |
| sel_is_async | output | 1 | Asynchronous tag of the selected generator |

## Verification
A wrong selection code or wrong decode appears at once on the tag outputs. It also shows within one cycle as events from a generator that is not selected. A toggle or edge-detect fault shows two edges after a source pulse, as a missing, doubled or widened pulse on `evt_sync`. A level synchronizer that is not cleared, or blanking that is missing, shows in the cycle right after a code write, as `evt_sync` going high too early. Any clocked stage on the raw path shows while the clock is stopped, as `evt_raw` failing to follow its input.

// File: rtl/evt_router_pkg.sv
package evt_router_pkg;

  typedef enum logic [1:0] {
    PATH_DIRECT   = 2'd0,
    PATH_PULSE_XS = 2'd1,
    PATH_LEVEL_XS = 2'd2
  } path_kind_e;

  // Which path a generator takes, from its two tags.
  function automatic path_kind_e path_of(input logic is_pulse, input logic is_async);
    if (!is_async)     return PATH_DIRECT;
    else if (is_pulse) return PATH_PULSE_XS;
    else               return PATH_LEVEL_XS;
  endfunction

  // True when a selection code addresses generator idx (code = idx + 1).
  function automatic logic code_hits(input int unsigned code, input int unsigned idx);
    return code == idx + 1;
  endfunction

endpackage

// File: rtl/evt_sel_reg.sv
module evt_sel_reg #(
  parameter int N_GEN = 6,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_code,
  output logic [SEL_W-1:0] code_q,
  output logic             blank_q,
  output logic [N_GEN-1:0] hot
);
  import evt_router_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      blank_q <= 1'b0;
    end else begin
      blank_q <= wr_en;
      if (wr_en) code_q <= wr_code;
    end
  end

  for (genvar i = 0; i < N_GEN; i++) begin : g_hot
    assign hot[i] = code_hits(int'(code_q), i);
  end

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hot)); // R1

endmodule

// File: rtl/evt_pulse_xsync.sv
module evt_pulse_xsync (
  input  logic src_clk,
  input  logic src_pulse,
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic pulse_o
);
  logic tog_src;
  logic s1, s2, s3;

  // Source domain: flip on every captured pulse.
  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n)         tog_src <= 1'b0;
    else if (src_pulse) tog_src <= ~tog_src;
  end

  // Peripheral domain: two flops plus an edge-detect stage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else if (clr) begin
      s1 <= tog_src;
      s2 <= s1;
      s3 <= s1;
    end else begin
      s1 <= tog_src;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign pulse_o = s2 ^ s3;

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o); // R4

endmodule

// File: rtl/evt_level_sync.sv
module evt_level_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic din,
  output logic lvl_o
);
  logic q1, q2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1 <= 1'b0;
      q2 <= 1'b0;
    end else if (clr) begin
      q1 <= 1'b0;
      q2 <= 1'b0;
    end else begin
      q1 <= din;
      q2 <= q1;
    end
  end

  assign lvl_o = q2;

  AST_LEVEL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !lvl_o); // R8

endmodule

// File: rtl/evt_chan_router.sv
module evt_chan_router #(
  parameter int               N_GEN     = 6,
  parameter int               SEL_W     = $clog2(N_GEN + 1),
  parameter logic [N_GEN-1:0] GEN_PULSE = 6'b010101,
  parameter logic [N_GEN-1:0] GEN_ASYNC = 6'b111100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_we,
  input  logic [SEL_W-1:0] sel_wdata,
  input  logic [N_GEN-1:0] gen_evt,
  input  logic [N_GEN-1:0] src_clk,
  output logic             evt_sync,
  output logic             evt_raw,
  output logic             sel_is_pulse,
  output logic             sel_is_async
);
  import evt_router_pkg::*;

  localparam int MAX_CODE = (1 << SEL_W) - 1;

  initial begin
    if (MAX_CODE < N_GEN) $error("SEL_W too narrow for N_GEN");
  end

  logic [SEL_W-1:0] code_q;
  logic             blank_q;
  logic [N_GEN-1:0] sel_hot;
  logic [N_GEN-1:0] path_evt;
  logic             chosen_sync;

  evt_sel_reg #(.N_GEN(N_GEN), .SEL_W(SEL_W)) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (sel_we),
    .wr_code (sel_wdata),
    .code_q  (code_q),
    .blank_q (blank_q),
    .hot     (sel_hot)
  );

  for (genvar i = 0; i < N_GEN; i++) begin : g_gen
    localparam path_kind_e KIND = path_of(GEN_PULSE[i], GEN_ASYNC[i]);
    if (KIND == PATH_PULSE_XS) begin : g_pxs
      evt_pulse_xsync u_pxs (
        .src_clk   (src_clk[i]),
        .src_pulse (gen_evt[i]),
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (sel_we),
        .pulse_o   (path_evt[i])
      );
    end else if (KIND == PATH_LEVEL_XS) begin : g_lxs
      logic unused_src;
      assign unused_src = src_clk[i];
      evt_level_sync u_lxs (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sel_we),
        .din   (gen_evt[i]),
        .lvl_o (path_evt[i])
      );
    end else begin : g_dir
      logic unused_src;
      assign unused_src = src_clk[i];
      assign path_evt[i] = gen_evt[i];
    end
  end

  always_comb begin
    chosen_sync = 1'b0;
    evt_raw     = 1'b0;
    for (int i = 0; i < N_GEN; i++) begin
      if (sel_hot[i]) begin
        chosen_sync = path_evt[i];
        if (GEN_ASYNC[i]) evt_raw = gen_evt[i];
      end
    end
  end

  assign evt_sync     = blank_q ? 1'b0 : chosen_sync;
  assign sel_is_pulse = |(sel_hot & GEN_PULSE);
  assign sel_is_async = |(sel_hot & GEN_ASYNC);

  logic unused_code;
  assign unused_code = ^code_q;

  AST_IDLE_NO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_hot == '0) |-> (!evt_sync && !evt_raw && !sel_is_pulse)); // R9
  AST_BLANK_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we |=> !evt_sync); // R8
  AST_RAW_SYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_is_async |-> !evt_raw); // R7

endmodule

// File: tb/evt_chan_router_tb_top.sv
`timescale 1ns/100ps
module evt_chan_router_tb_top;
  logic       clk = 1'b0;
  logic       clk_run = 1'b1;
  logic       sclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_we = 1'b0;
  logic [2:0] sel_wdata = '0;
  logic [5:0] gen_evt = '0;
  logic [5:0] src_clk;
  logic       evt_sync, evt_raw, sel_is_pulse, sel_is_async;
  int         n_checks = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  assign src_clk = {1'b0, sclk, 1'b0, sclk, 1'b0, 1'b0};

  initial forever begin
    #2.5;
    if (clk_run) clk = ~clk;
  end
  initial forever #3.5 sclk = ~sclk;

  evt_chan_router dut_i (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .gen_evt(gen_evt), .src_clk(src_clk), .evt_sync(evt_sync),
    .evt_raw(evt_raw), .sel_is_pulse(sel_is_pulse), .sel_is_async(sel_is_async)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Write a code; returns at the negedge right after the write edge.
  task automatic write_sel(input logic [2:0] code);
    @(negedge clk);
    sel_we = 1'b1;
    sel_wdata = code;
    @(negedge clk);
    sel_we = 1'b0;
    check("R8", "evt_sync blanked after write", evt_sync, 0);
  endtask

  task automatic t_reset;
    check("R2", "evt_sync at reset", evt_sync, 0);
    check("R2", "evt_raw at reset", evt_raw, 0);
    check("R2", "tags at reset", {sel_is_pulse, sel_is_async}, 0);
  endtask

  task automatic t_sync_pulse;
    write_sel(3'd1);
    @(negedge clk);
    check("R10", "tags gen0", {sel_is_pulse, sel_is_async}, 2);
    gen_evt[0] = 1'b1;
    #1 check("R3", "sync pulse passes same cycle", evt_sync, 1);
    check("R7", "raw quiet for sync gen", evt_raw, 0);
    @(negedge clk);
    gen_evt[0] = 1'b0;
    #1 check("R3", "sync pulse one cycle", evt_sync, 0);
  endtask

  task automatic t_sync_level_only_selected;
    write_sel(3'd2);
    @(negedge clk);
    check("R10", "tags gen1", {sel_is_pulse, sel_is_async}, 0);
    gen_evt[0] = 1'b1;
    #1 check("R1", "unselected gen0 ignored", evt_sync, 0);
    gen_evt[0] = 1'b0;
    gen_evt[1] = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R3", "sync level held", evt_sync, 1);
    end
    gen_evt[1] = 1'b0;
    #1 check("R3", "sync level released", evt_sync, 0);
  endtask

  task automatic t_async_level;
    write_sel(3'd4);
    repeat (3) @(negedge clk);
    check("R10", "tags gen3", {sel_is_pulse, sel_is_async}, 1);
    gen_evt[3] = 1'b1;
    #1 check("R6", "raw follows async level", evt_raw, 1);
    @(negedge clk);
    check("R5", "one edge: not yet", evt_sync, 0);
    @(negedge clk);
    check("R5", "two edges: high", evt_sync, 1);
    gen_evt[3] = 1'b0;
    @(negedge clk);
    check("R5", "fall one edge: still high", evt_sync, 1);
    @(negedge clk);
    check("R5", "fall two edges: low", evt_sync, 0);
  endtask

  task automatic t_raw_clock_stopped;
    @(negedge clk);
    clk_run = 1'b0;
    #20 gen_evt[3] = 1'b1;
    #3 check("R6", "raw rises with clock stopped", evt_raw, 1);
    check("R6", "sync holds with clock stopped", evt_sync, 0);
    #10 gen_evt[3] = 1'b0;
    #3 check("R6", "raw falls with clock stopped", evt_raw, 0);
    clk_run = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_async_pulse;
    write_sel(3'd3);
    repeat (4) @(negedge clk);
    check("R10", "tags gen2", {sel_is_pulse, sel_is_async}, 3);
    for (int p = 0; p < 3; p++) begin
      int cnt = 0;
      @(posedge sclk);
      #0.5 gen_evt[2] = 1'b1;
      #0.5 check("R6", "raw shows async pulse", evt_raw, 1);
      @(posedge sclk);
      #0.5 gen_evt[2] = 1'b0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (evt_sync) cnt++;
      end
      check("R4", "one sync pulse per source pulse", cnt, 1);
    end
  endtask

  task automatic t_switch_clears;
    write_sel(3'd4);
    gen_evt[3] = 1'b1;
    gen_evt[5] = 1'b1;
    repeat (3) @(negedge clk);
    check("R5", "gen3 level synced", evt_sync, 1);
    write_sel(3'd6);
    @(negedge clk);
    check("R8", "cleared sync: low one edge later", evt_sync, 0);
    @(negedge clk);
    check("R8", "new level after two edges", evt_sync, 1);
    gen_evt[3] = 1'b0;
    gen_evt[5] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_out_of_range;
    write_sel(3'd7);
    gen_evt[0] = 1'b1;
    gen_evt[1] = 1'b1;
    gen_evt[3] = 1'b1;
    gen_evt[5] = 1'b1;
    repeat (3) @(negedge clk);
    check("R9", "code 7 evt_sync", evt_sync, 0);
    check("R9", "code 7 evt_raw", evt_raw, 0);
    check("R9", "code 7 tags", {sel_is_pulse, sel_is_async}, 0);
    write_sel(3'd0);
    repeat (3) @(negedge clk);
    check("R9", "code 0 evt_sync", evt_sync, 0);
    check("R7", "code 0 evt_raw", evt_raw, 0);
    gen_evt = '0;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sync_pulse();
    t_sync_level_only_selected();
    t_async_level();
    t_raw_clock_stopped();
    t_async_pulse();
    t_switch_clears();
    t_out_of_range();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule